// File: doc/BRIEF.md
# Full-Duplex SPI Port (Master or Slave)

This block is a byte-wide serial peripheral interface port that can work as bus master or as bus slave. Software sets a role, a clock polarity, a clock phase, a bit order and, for the master, a serial clock rate. It then exchanges one byte at a time with the far end. In the master role a write to the data holding port starts eight bit times of SCK, shifting the written byte out on MOSI while MISO is shifted in. In the slave role the port follows the SCK and MOSI of an external master while its slave-select input is low, and drives MISO only during that time.

Each finished byte lands in a receive buffer and raises a completion flag. A write while a byte is in flight raises a collision flag and is dropped. Both flags are cleared by a status read followed by a data access. A master whose slave-select input is pulled low by another device gives up the bus, falls back to the slave role and raises the completion flag so that software notices.

Top module: `spi_port`

## Requirements
- R1: The idle SCK level equals the polarity bit. With phase 0 each bit is sampled on the leading SCK edge (the first edge away from idle) and the next bit is presented on the trailing edge. With phase 1 the next bit is presented on the leading edge and sampled on the trailing edge.
- R2: With the order bit at 1, bit 0 of a byte travels first and bit 7 last. With the order bit at 0, bit 7 travels first.
- R3: In the master role a data write while idle makes 16 SCK edges (8 bit times). After the last edge `rdata` holds the byte received on MISO and `done_flag` is 1.
- R4: In the slave role, while slave-select is low, the port shifts on SCK and drives MISO (`miso_oe`=1). While slave-select is high `miso_oe` is 0 and SCK edges change neither `rdata` nor `done_flag`.
- R5: If slave-select rises in the middle of a slave byte, the partial byte is dropped: `done_flag` stays 0, `rdata` keeps its old value, and the next byte is received whole.
- R6: The master SCK half period, in system clocks, is set by {dbl, rate}: 000→2, 001→8, 010→32, 011→64, 100→1, 101→4, 110→16, 111→32. This gives divisors of 4, 16, 64, 128, 2, 8, 32 and 64.
- R7: In the slave role the rate and double-speed bits have no effect on what is received or sent.
- R8: In the master role, a low level on slave-select makes the port leave the master role (`role_master`=0) and sets `done_flag`.
- R9: A data write while a byte is in flight sets `wcol_flag`. The byte in flight keeps shifting the data written before it.
- R10: `done_flag` and `wcol_flag` clear only on a data read or write that follows a status read made while `done_flag` was 1. A data read alone leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration inputs below |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1 = bit 0 first |
| cfg_rate | input | 2 | Master rate select |
| cfg_dbl | input | 1 | Master double-speed bit |
| wr_data | input | 1 | Data write strobe |
| wdata | input | 8 | Byte to send |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| rdata | output | 8 | Last received byte |
| done_flag | output | 1 | Transfer complete flag |
| wcol_flag | output | 1 | Write collision flag |
| role_master | output | 1 | Current role (1 = master) |
| sck_out | output | 1 | Master SCK |
| mosi_out | output | 1 | Master data out |
| sck_mosi_oe | output | 1 | Enable for master SCK and MOSI drivers |
| sck_in | input | 1 | Slave SCK from bus |
| mosi_in | input | 1 | Slave data in from bus |
| ss_n_in | input | 1 | Slave-select, active low |
| miso_in | input | 1 | Master data in from bus |
| miso_out | output | 1 | Slave data out |
| miso_oe | output | 1 | Tristate enable for MISO |

## Verification
The master role is run against a bench slave model in all four polarity and phase pairs, with both bit orders. The byte patterns are asymmetric, so a reversed order, a swapped sample edge or an off-by-one shift each give a different byte on at least one side. The slave role is driven by a bench master with the same mode pairs at two rate settings, which shows that the rate bits are ignored. Further runs cover an aborted slave byte, SCK edges while deselected, a mid-byte write, the flag clearing sequence with and without the status read, and a bus takeover of the master. The SCK half period is measured at all seven rates.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       cfg_master,
  input  logic       cfg_cpol,
  input  logic       cfg_cpha,
  input  logic       cfg_lsb_first,
  input  logic [1:0] cfg_rate,
  input  logic       cfg_dbl,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  input  logic       rd_status,
  input  logic       rd_data,
  output logic [7:0] rdata,
  output logic       done_flag,
  output logic       wcol_flag,
  output logic       role_master,
  output logic       sck_out,
  output logic       mosi_out,
  output logic       sck_mosi_oe,
  input  logic       sck_in,
  input  logic       mosi_in,
  input  logic       ss_n_in,
  input  logic       miso_in,
  output logic       miso_out,
  output logic       miso_oe
);

  localparam int BITS  = 8;
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);
  localparam int CW    = 7;

  logic en_q, mstr_q, cpol_q, cpha_q, lsb_q, dbl_q;
  logic [1:0] rate_q;
  logic [BITS-1:0] sr, rbuf;
  logic out_bit, rx_bit, busy_q, sck_r, done_q, wcol_q, armed_q;
  logic [EW-1:0] ecnt;
  logic [CW-1:0] cnt, half;
  logic ss_s1, ss_s2, sck_s1, sck_s2, sck_d, mosi_s1, mosi_s2;

  always_comb begin
    case ({dbl_q, rate_q})
      3'b000:  half = 7'd2;
      3'b001:  half = 7'd8;
      3'b010:  half = 7'd32;
      3'b011:  half = 7'd64;
      3'b100:  half = 7'd1;
      3'b101:  half = 7'd4;
      3'b110:  half = 7'd16;
      default: half = 7'd32;
    endcase
  end

  logic m_run, tick, sel, ev, lead, din, lead_ev, trail_ev, last, mfault, bitin;
  logic [BITS-1:0] shifted;

  assign m_run    = en_q & mstr_q & busy_q;
  assign tick     = m_run & (cnt == half - 7'd1);
  assign sel      = en_q & ~mstr_q & ~ss_s2;
  assign ev       = mstr_q ? tick : (sel & (sck_s2 ^ sck_d));
  assign lead     = mstr_q ? ~ecnt[0] : (sck_s2 != cpol_q);
  assign din      = mstr_q ? miso_in : mosi_s2;
  assign lead_ev  = ev & lead;
  assign trail_ev = ev & ~lead;
  assign last     = trail_ev & (ecnt == EW'(EDGES - 1));
  assign mfault   = en_q & mstr_q & ~ss_s2;
  assign bitin    = cpha_q ? din : rx_bit;
  assign shifted  = lsb_q ? {bitin, sr[BITS-1:1]} : {sr[BITS-2:0], bitin};

  function automatic logic first_bit(input logic lsb, input logic [BITS-1:0] v);
    return lsb ? v[0] : v[BITS-1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mstr_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      lsb_q <= 1'b0; dbl_q <= 1'b0; rate_q <= 2'd0;
      sr <= '0; rbuf <= '0; out_bit <= 1'b0; rx_bit <= 1'b0;
      busy_q <= 1'b0; sck_r <= 1'b0; done_q <= 1'b0; wcol_q <= 1'b0; armed_q <= 1'b0;
      ecnt <= '0; cnt <= '0;
      ss_s1 <= 1'b1; ss_s2 <= 1'b1; sck_s1 <= 1'b0; sck_s2 <= 1'b0; sck_d <= 1'b0;
      mosi_s1 <= 1'b0; mosi_s2 <= 1'b0;
    end else begin
      ss_s1 <= ss_n_in; ss_s2 <= ss_s1;
      sck_s1 <= sck_in; sck_s2 <= sck_s1; sck_d <= sck_s2;
      mosi_s1 <= mosi_in; mosi_s2 <= mosi_s1;

      if (cfg_wr) begin
        en_q <= cfg_en; mstr_q <= cfg_master; cpol_q <= cfg_cpol; cpha_q <= cfg_cpha;
        lsb_q <= cfg_lsb_first; rate_q <= cfg_rate; dbl_q <= cfg_dbl;
        busy_q <= 1'b0; ecnt <= '0; cnt <= '0; sck_r <= cfg_cpol;
      end else if (mfault) begin
        mstr_q <= 1'b0; busy_q <= 1'b0; ecnt <= '0; cnt <= '0;
        sck_r <= cpol_q; done_q <= 1'b1;
      end else begin
        if (rd_status && done_q) armed_q <= 1'b1;
        if (armed_q && (rd_data || wr_data)) begin
          done_q <= 1'b0; wcol_q <= 1'b0; armed_q <= 1'b0;
        end

        if (!mstr_q && ss_s2) begin
          busy_q <= 1'b0; ecnt <= '0;
        end

        if (wr_data && en_q) begin
          if (busy_q) wcol_q <= 1'b1;
          else begin
            sr <= wdata;
            out_bit <= first_bit(lsb_q, wdata);
            if (mstr_q) begin
              busy_q <= 1'b1; cnt <= '0; ecnt <= '0;
            end
          end
        end

        if (m_run) begin
          cnt <= tick ? '0 : cnt + 7'd1;
          if (tick) sck_r <= ~sck_r;
        end

        if (ev) begin
          ecnt <= ecnt + 1'b1;
          busy_q <= 1'b1;
          if (lead_ev) begin
            if (!cpha_q) rx_bit <= din;
            else out_bit <= first_bit(lsb_q, sr);
          end
          if (trail_ev) begin
            sr <= shifted;
            if (!cpha_q) out_bit <= lsb_q ? sr[1] : sr[BITS-2];
          end
          if (last) begin
            busy_q <= 1'b0; done_q <= 1'b1; rbuf <= shifted; ecnt <= '0;
          end
        end
      end
    end
  end

  assign rdata       = rbuf;
  assign done_flag   = done_q;
  assign wcol_flag   = wcol_q;
  assign role_master = mstr_q;
  assign sck_out     = sck_r;
  assign mosi_out    = out_bit;
  assign sck_mosi_oe = en_q & mstr_q;
  assign miso_out    = out_bit;
  assign miso_oe     = sel;

  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_out == cpol_q);

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mstr_q && !cfg_wr && !mfault && tick && ecnt == EW'(EDGES - 1) |=> done_flag && !busy_q);

  p_miso_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_in |-> ##2 !miso_oe);

  p_fault_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mstr_q && en_q && !ss_s2 && !cfg_wr |=> !role_master && done_flag);

  p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && en_q && busy_q && !cfg_wr && !mfault |=> wcol_flag);

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !armed_q && !cfg_wr |=> done_flag);

endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_en = 0, cfg_master = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_dbl = 0;
  logic [1:0] cfg_rate = 0;
  logic wr_data = 0, rd_status = 0, rd_data = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic done_flag, wcol_flag, role_master, sck_out, mosi_out, sck_mosi_oe, miso_out, miso_oe;
  logic sck_in = 0, mosi_in = 0, ss_n_in = 1, miso_in = 0;

  spi_port dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] expq[$];
  string tagq[$];
  logic [7:0] cap_byte, m_reply;
  int m_k;
  bit model_on = 0, cur_lsb = 0, cur_cpha = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bp(input int i);
    return cur_lsb ? i : 7 - i;
  endfunction

  // bench slave model serving the master role
  always @(sck_out) if (model_on) begin
    int k;
    #1;
    k = m_k; m_k++;
    if (!cur_cpha) begin
      if (k % 2 == 0) cap_byte[bp(k/2)] = mosi_out;
      else if (k < 15) miso_in = m_reply[bp((k+1)/2)];
    end else begin
      if (k % 2 == 0) miso_in = m_reply[bp(k/2)];
      else cap_byte[bp(k/2)] = mosi_out;
    end
  end

  // scoreboard monitor
  logic done_prev = 0;
  always @(negedge clk) begin
    if (done_flag && !done_prev && expq.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(rdata == e[15:8], {t, " rdata"}, rdata, e[15:8]);
      chk(cap_byte == e[7:0], {t, " far-end byte"}, cap_byte, e[7:0]);
    end
    done_prev = done_flag;
  end

  task automatic cfg(input bit en, master, cpol, cpha, lsb, input logic [1:0] rate, input bit dbl);
    @(negedge clk);
    cfg_en = en; cfg_master = master; cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_lsb_first = lsb; cfg_rate = rate; cfg_dbl = dbl; cfg_wr = 1;
    cur_lsb = lsb; cur_cpha = cpha;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); wdata = d; wr_data = 1;
    @(negedge clk); wr_data = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); rd_status = 1;
    @(negedge clk); rd_status = 0; rd_data = 1;
    @(negedge clk); rd_data = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_flag && n < 5000) begin @(negedge clk); n++; end
    chk(done_flag, {tag, " completion"}, done_flag, 1);
  endtask

  task automatic master_xfer(input logic [7:0] tx, reply, input string tag, output int half_meas);
    logic prev;
    int c;
    m_reply = reply; m_k = 0; cap_byte = 0;
    if (!cur_cpha) miso_in = reply[bp(0)];
    expq.push_back({reply, tx}); tagq.push_back(tag);
    model_on = 1;
    pulse_wr(tx);
    prev = sck_out;
    while (sck_out == prev) @(negedge clk);
    prev = sck_out; c = 0;
    do begin @(negedge clk); c++; end while (sck_out == prev);
    half_meas = c;
    wait_done(tag);
    model_on = 0;
    repeat (2) @(negedge clk);
    clear_flags();
  endtask

  task automatic slave_xfer(input logic [7:0] btx, stx, input bit cpol, input int nedges, input string tag);
    cap_byte = 0;
    sck_in = cpol;
    pulse_wr(stx);
    if (nedges == 16) begin expq.push_back({btx, stx}); tagq.push_back(tag); end
    @(negedge clk); ss_n_in = 0;
    if (!cur_cpha) mosi_in = btx[bp(0)];
    repeat (8) @(negedge clk);
    for (int k = 0; k < nedges; k++) begin
      if (!cur_cpha) begin
        if (k % 2 == 0) begin cap_byte[bp(k/2)] = miso_out; sck_in = ~sck_in; end
        else begin sck_in = ~sck_in; if (k < 15) mosi_in = btx[bp((k+1)/2)]; end
      end else begin
        if (k % 2 == 0) begin sck_in = ~sck_in; mosi_in = btx[bp(k/2)]; end
        else begin cap_byte[bp(k/2)] = miso_out; sck_in = ~sck_in; end
      end
      repeat (8) @(negedge clk);
    end
    ss_n_in = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done_flag == 0 && wcol_flag == 0, "reset flags R3", {done_flag, wcol_flag}, 0);
    chk(miso_oe == 0 && sck_mosi_oe == 0 && role_master == 0, "reset drivers R4", {miso_oe, sck_mosi_oe, role_master}, 0);

    // R1, R2, R3: master in all modes and both orders
    for (int m = 0; m < 8; m++) begin
      bit pol = m[0], pha = m[1], lsb = m[2];
      cfg(1, 1, pol, pha, lsb, 2'd0, 1'b1);
      @(negedge clk);
      chk(sck_out == pol, "idle SCK level R1", sck_out, pol);
      master_xfer(8'h1D ^ 8'(m * 37), 8'hB4 ^ 8'(m * 11), $sformatf("master mode %0d R1 R2 R3", m), h);
    end

    // R6: every rate
    for (int r = 0; r < 8; r++) begin
      int exp_h;
      case (r)
        0: exp_h = 2; 1: exp_h = 8; 2: exp_h = 32; 3: exp_h = 64;
        4: exp_h = 1; 5: exp_h = 4; 6: exp_h = 16; default: exp_h = 32;
      endcase
      cfg(1, 1, 0, 0, 0, 2'(r), r[2]);
      master_xfer(8'h5A, 8'hC3, "rate R6", h);
      chk(h == exp_h, $sformatf("SCK half period sel=%0d R6", r), h, exp_h);
    end

    // R9, R10: collision and flag clearing
    cfg(1, 1, 0, 0, 0, 2'd1, 1'b0);
    m_reply = 8'h96; m_k = 0; cap_byte = 0; miso_in = m_reply[7];
    expq.push_back({8'h96, 8'hE1}); tagq.push_back("collision R9");
    model_on = 1;
    pulse_wr(8'hE1);
    repeat (30) @(negedge clk);
    pulse_wr(8'h00);
    @(negedge clk);
    chk(wcol_flag == 1, "wcol set R9", wcol_flag, 1);
    wait_done("collision R9");
    model_on = 0;
    @(negedge clk); rd_data = 1; @(negedge clk); rd_data = 0; @(negedge clk);
    chk(done_flag == 1 && wcol_flag == 1, "flags kept without status read R10", {done_flag, wcol_flag}, 3);
    clear_flags();
    chk(done_flag == 0 && wcol_flag == 0, "flags cleared R10", {done_flag, wcol_flag}, 0);

    // R4, R5, R7: slave role
    for (int m = 0; m < 4; m++) begin
      cfg(1, 0, m[0], m[1], m[1] ^ m[0], 2'(m), m[0]);
      slave_xfer(8'h3C ^ 8'(m * 29), 8'hA7 ^ 8'(m * 13), m[0], 16, $sformatf("slave mode %0d R4", m));
      chk(done_flag == 1, "slave done R4", done_flag, 1);
      clear_flags();
    end
    cfg(1, 0, 0, 1, 0, 2'd3, 1'b0);
    slave_xfer(8'h71, 8'h8E, 0, 16, "slave slow rate bits R7");
    clear_flags();
    cfg(1, 0, 0, 1, 0, 2'd0, 1'b1);
    slave_xfer(8'h71, 8'h8E, 0, 16, "slave fast rate bits R7");
    clear_flags();

    // R4: SCK while deselected
    sck_in = 0;
    @(negedge clk);
    chk(miso_oe == 0, "MISO released R4", miso_oe, 0);
    for (int k = 0; k < 16; k++) begin sck_in = ~sck_in; repeat (8) @(negedge clk); end
    chk(done_flag == 0 && rdata == 8'h71, "deselected SCK ignored R4", {done_flag, rdata}, 9'h071);

    // R5: abort mid-byte
    slave_xfer(8'hFF, 8'h00, 0, 6, "abort R5");
    chk(done_flag == 0, "abort no completion R5", done_flag, 0);
    chk(rdata == 8'h71, "abort keeps rdata R5", rdata, 8'h71);
    slave_xfer(8'h29, 8'hD2, 0, 16, "after abort R5");
    clear_flags();

    // R8: master loses the bus
    cfg(1, 1, 0, 0, 0, 2'd0, 1'b0);
    @(negedge clk);
    chk(role_master == 1, "master role R8", role_master, 1);
    ss_n_in = 0;
    repeat (5) @(negedge clk);
    chk(role_master == 0, "drop to slave R8", role_master, 0);
    chk(done_flag == 1, "flag on takeover R8", done_flag, 1);
    ss_n_in = 1;
    clear_flags();

    chk(expq.size() == 0, "all transfers completed R3", expq.size(), 0);
    finish_run();
  end
endmodule